// File: doc/BRIEF.md
# Multicycle processor control FSM

This block is the control sequencer of a small 32-bit multicycle RISC core. Each instruction takes a two-cycle fetch and one decode cycle. Decode then moves to one or two execute states, chosen from the primary and extended opcode fields of the instruction register. Every control output depends only on the current state, so the outputs are Moore-style. The one exception is the 6-bit ALU operation code, which is decoded directly from the opcode fields. The datapath holds those fields stable in the instruction register for the whole instruction.

The datapath receives the register-file, memory, PC and ALU steering signals from this block. The register file, ALU and memories are not part of it. A branch state only requests a conditional PC update through the branch flag. The datapath combines that flag with the ALU result.

Top module: `mcc_ctrl`

## Requirements
- R1: The reset `rst_ni` is asynchronous and active low. While it is low, the machine is in the first fetch state, so `mem_rd_o` is 1 and every other control is 0.
- R2: The sequence is first fetch (read only), then second fetch (`ir_en_o` and `pc_en_o`), then decode (all controls 0). In none of these three cycles are `mem_wr_o`, `rf_we_o` or `branch_o` high.
- R3: `ir_en_o` is high only when `mem_rd_o` was high in the cycle before, and never together with `addr_data_o`.
- R4: Between the first fetch and the end of decode, `pc_en_o` is high for exactly one cycle. In that cycle `pc_add_imm_o`, `pc_sel_a_o` and `pc_sel_imm_o` are 0 (plain +4).
- R5: A register-format instruction has primary opcode 0x3A. For an ALU extended opcode, it executes one cycle with `rf_we_o`, `wsel_rc_o` and `b_reg_o` set. The ALU code comes from the extended opcode: 0x31 gives 000000 (add) and 0x39 gives 001000 (sub).
- R6: A register-format shift by immediate (extended 0x12, 0x1A, 0x3A or 0x02) executes one cycle with `rf_we_o` and `wsel_rc_o` set and `b_reg_o` at 0. Extended 0x12 gives ALU 110010.
- R7: Immediate ALU instructions execute one cycle with `rf_we_o` set and `b_reg_o` at 0.
  - Primary 0x04 and 0x08 also set `imm_signed_o`, with ALU 000000 and 011001.
  - Primary 0x0C and 0x34 leave `imm_signed_o` at 0, with ALU 100001 and 100010.
- R8: A load (primary 0x17) takes two execute cycles.
  - The first sets `mem_rd_o`, `addr_data_o` and `imm_signed_o`, with no register write.
  - The second sets `wdata_mem_o` and `rf_we_o`.
- R9: A store (primary 0x15) executes one cycle with `mem_wr_o`, `addr_data_o` and `imm_signed_o` set, and with `rf_we_o` and `pc_en_o` at 0.
- R10: A branch (primary 0x06, 0x0E, 0x16, 0x1E, 0x26, 0x2E or 0x36) executes one cycle with `branch_o`, `b_reg_o`, `pc_add_imm_o` and `imm_signed_o` set, and `pc_en_o` at 0.
  - For 0x06 (always taken), the ALU code is 011100, a compare that is always true with equal operands.
  - 0x0E gives 011001.
- R11: A call sets `pc_en_o`, `wdata_pc_o`, `wsel_ra_o` and `rf_we_o`.
  - For primary 0x00 it also sets `pc_sel_imm_o`.
  - For primary 0x3A with extended 0x1D it sets `pc_sel_a_o` instead.
- R12: A jump through register A (primary 0x3A, extended 0x0D or 0x05) sets `pc_en_o` and `pc_sel_a_o`. A jump to the immediate target (primary 0x00 is taken by the call; the jump uses 0x01) sets `pc_en_o` and `pc_sel_imm_o`. Neither writes the register file.
- R13: A halt (primary 0x3A, extended 0x34) drives every control low and stays in that state until reset, whatever the opcode inputs do.
- R14: Every execute state other than the first load cycle and the halt returns to the first fetch state on the next cycle. An undefined primary or extended opcode goes from decode straight to the first fetch state with no control asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Primary opcode from the instruction register |
| opx_i | input | 6 | Extended opcode from the instruction register |
| ir_en_o | output | 1 | Instruction register load |
| pc_en_o | output | 1 | PC update enable |
| pc_add_imm_o | output | 1 | PC adds the immediate offset |
| pc_sel_a_o | output | 1 | PC loads from register A |
| pc_sel_imm_o | output | 1 | PC loads the immediate target |
| rf_we_o | output | 1 | Register-file write enable |
| wsel_rc_o | output | 1 | Write address from the rC field |
| wsel_ra_o | output | 1 | Write address is the return-address register |
| wdata_pc_o | output | 1 | Write data is the PC |
| wdata_mem_o | output | 1 | Write data is memory read data |
| b_reg_o | output | 1 | ALU operand B from register B |
| imm_signed_o | output | 1 | Sign-extend the immediate |
| branch_o | output | 1 | Conditional branch request |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| addr_data_o | output | 1 | Memory address from the ALU (data access) |
| alu_op_o | output | 6 | ALU operation code |

## Verification
The assertions check, on every cycle, these cycle-level rules:
- fetch and decode never write;
- the instruction register loads only after a read and never on a data address;
- the PC is updated exactly once per fetch;
- stores and loads drive the correct strobes;
- the always-taken branch uses an always-true compare;
- the halt state is sticky and the other execute states return to fetch.

Only the bench scenarios can show that each opcode actually reaches the intended path with the intended ALU code. The same holds for what an undefined opcode does and for the asynchronous effect of reset in the middle of an instruction.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  parameter int unsigned OP_W  = 6;
  parameter int unsigned ALU_W = 6;
  localparam int unsigned ST_W = 5;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH_A, ST_FETCH_B, ST_DECODE, ST_REG, ST_REG_IMM, ST_IMM_S,
    ST_IMM_U, ST_LD_ADDR, ST_LD_WB, ST_ST, ST_BR, ST_CALL, ST_CALL_REG,
    ST_JMP_REG, ST_HALT, ST_JMP_IMM, ST_IMM_HI
  } mcc_state_e;

  typedef struct packed {
    logic ir_en;
    logic pc_en;
    logic pc_add_imm;
    logic pc_sel_a;
    logic pc_sel_imm;
    logic rf_we;
    logic wsel_rc;
    logic wsel_ra;
    logic wdata_pc;
    logic wdata_mem;
    logic b_reg;
    logic imm_signed;
    logic branch;
    logic mem_rd;
    logic mem_wr;
    logic addr_data;
  } mcc_ctrl_t;

  // primary opcodes
  localparam logic [OP_W-1:0] OP_REGFMT    = 6'h3A;
  localparam logic [OP_W-1:0] OP_CALL      = 6'h00;
  localparam logic [OP_W-1:0] OP_JMP_IMM   = 6'h01;
  localparam logic [OP_W-1:0] OP_LOAD      = 6'h17;
  localparam logic [OP_W-1:0] OP_STORE     = 6'h15;
  localparam logic [OP_W-1:0] OP_BR_ALWAYS = 6'h06;

  // extended opcodes
  localparam logic [OP_W-1:0] OPX_CALL_REG = 6'h1D;
  localparam logic [OP_W-1:0] OPX_JMP_REG  = 6'h0D;
  localparam logic [OP_W-1:0] OPX_RET      = 6'h05;
  localparam logic [OP_W-1:0] OPX_HALT     = 6'h34;

  // ALU operation codes
  localparam logic [ALU_W-1:0] ALU_ADD   = 6'b000000;
  localparam logic [ALU_W-1:0] ALU_SUB   = 6'b001000;
  localparam logic [ALU_W-1:0] ALU_CLE   = 6'b011001;
  localparam logic [ALU_W-1:0] ALU_CGT   = 6'b011010;
  localparam logic [ALU_W-1:0] ALU_CNE   = 6'b011011;
  localparam logic [ALU_W-1:0] ALU_CEQ   = 6'b011100;
  localparam logic [ALU_W-1:0] ALU_CLEU  = 6'b011101;
  localparam logic [ALU_W-1:0] ALU_CGTU  = 6'b011110;
  localparam logic [ALU_W-1:0] ALU_AND   = 6'b100001;
  localparam logic [ALU_W-1:0] ALU_OR    = 6'b100010;
  localparam logic [ALU_W-1:0] ALU_XOR   = 6'b100011;
  localparam logic [ALU_W-1:0] ALU_ROL   = 6'b110000;
  localparam logic [ALU_W-1:0] ALU_SLL   = 6'b110010;
  localparam logic [ALU_W-1:0] ALU_SRL   = 6'b110011;
  localparam logic [ALU_W-1:0] ALU_SRA   = 6'b110111;
endpackage

// File: rtl/mcc_next.sv
module mcc_next
  import mcc_pkg::*;
(
  input  mcc_state_e           state_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [OP_W-1:0]      opx_i,
  output mcc_state_e           next_o
);
  mcc_state_e prim_tgt, ext_tgt;

  always_comb begin
    unique case (opx_i)
      OPX_CALL_REG:                 ext_tgt = ST_CALL_REG;
      OPX_JMP_REG, OPX_RET:         ext_tgt = ST_JMP_REG;
      OPX_HALT:                     ext_tgt = ST_HALT;
      6'h12, 6'h1A, 6'h3A, 6'h02:   ext_tgt = ST_REG_IMM;
      6'h31, 6'h39, 6'h08, 6'h10, 6'h18, 6'h20, 6'h28, 6'h30,
      6'h0E, 6'h16, 6'h1E, 6'h13, 6'h1B, 6'h3B, 6'h03:
                                    ext_tgt = ST_REG;
      default:                      ext_tgt = ST_FETCH_A;
    endcase
  end

  always_comb begin
    unique case (op_i)
      OP_REGFMT:   prim_tgt = ext_tgt;
      OP_CALL:     prim_tgt = ST_CALL;
      OP_JMP_IMM:  prim_tgt = ST_JMP_IMM;
      OP_LOAD:     prim_tgt = ST_LD_ADDR;
      OP_STORE:    prim_tgt = ST_ST;
      6'h06, 6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36:
                   prim_tgt = ST_BR;
      6'h04, 6'h08, 6'h10, 6'h18, 6'h20:
                   prim_tgt = ST_IMM_S;
      6'h0C, 6'h14, 6'h1C, 6'h28, 6'h30:
                   prim_tgt = ST_IMM_U;
      6'h34:       prim_tgt = ST_IMM_HI;
      default:     prim_tgt = ST_FETCH_A;
    endcase
  end

  always_comb begin
    unique case (state_i)
      ST_FETCH_A: next_o = ST_FETCH_B;
      ST_FETCH_B: next_o = ST_DECODE;
      ST_DECODE:  next_o = prim_tgt;
      ST_LD_ADDR: next_o = ST_LD_WB;
      ST_HALT:    next_o = ST_HALT;
      default:    next_o = ST_FETCH_A;
    endcase
  end
endmodule

// File: rtl/mcc_outputs.sv
module mcc_outputs
  import mcc_pkg::*;
(
  input  mcc_state_e state_i,
  output mcc_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH_A: ctrl_o.mem_rd = 1'b1;
      ST_FETCH_B: begin
        ctrl_o.ir_en = 1'b1;
        ctrl_o.pc_en = 1'b1;
      end
      ST_REG: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wsel_rc = 1'b1;
        ctrl_o.b_reg   = 1'b1;
      end
      ST_REG_IMM: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.wsel_rc = 1'b1;
      end
      ST_IMM_S: begin
        ctrl_o.rf_we      = 1'b1;
        ctrl_o.imm_signed = 1'b1;
      end
      ST_IMM_U, ST_IMM_HI: ctrl_o.rf_we = 1'b1;
      ST_LD_ADDR: begin
        ctrl_o.mem_rd     = 1'b1;
        ctrl_o.addr_data  = 1'b1;
        ctrl_o.imm_signed = 1'b1;
      end
      ST_LD_WB: begin
        ctrl_o.wdata_mem = 1'b1;
        ctrl_o.rf_we     = 1'b1;
      end
      ST_ST: begin
        ctrl_o.mem_wr     = 1'b1;
        ctrl_o.addr_data  = 1'b1;
        ctrl_o.imm_signed = 1'b1;
      end
      ST_BR: begin
        ctrl_o.branch     = 1'b1;
        ctrl_o.b_reg      = 1'b1;
        ctrl_o.pc_add_imm = 1'b1;
        ctrl_o.imm_signed = 1'b1;
      end
      ST_CALL, ST_CALL_REG: begin
        ctrl_o.pc_en      = 1'b1;
        ctrl_o.pc_sel_imm = (state_i == ST_CALL);
        ctrl_o.pc_sel_a   = (state_i == ST_CALL_REG);
        ctrl_o.wdata_pc   = 1'b1;
        ctrl_o.wsel_ra    = 1'b1;
        ctrl_o.rf_we      = 1'b1;
      end
      ST_JMP_REG: begin
        ctrl_o.pc_en    = 1'b1;
        ctrl_o.pc_sel_a = 1'b1;
      end
      ST_JMP_IMM: begin
        ctrl_o.pc_en      = 1'b1;
        ctrl_o.pc_sel_imm = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mcc_alu_map.sv
module mcc_alu_map
  import mcc_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [OP_W-1:0]  opx_i,
  output logic [ALU_W-1:0] alu_op_o
);
  logic [ALU_W-1:0] prim_alu, ext_alu;

  always_comb begin
    unique case (opx_i)
      6'h31:        ext_alu = ALU_ADD;
      6'h39:        ext_alu = ALU_SUB;
      6'h08:        ext_alu = ALU_CLE;
      6'h10:        ext_alu = ALU_CGT;
      6'h18:        ext_alu = ALU_CNE;
      6'h20:        ext_alu = ALU_CEQ;
      6'h28:        ext_alu = ALU_CLEU;
      6'h30:        ext_alu = ALU_CGTU;
      6'h0E:        ext_alu = ALU_AND;
      6'h16:        ext_alu = ALU_OR;
      6'h1E:        ext_alu = ALU_XOR;
      6'h13, 6'h12: ext_alu = ALU_SLL;
      6'h1B, 6'h1A: ext_alu = ALU_SRL;
      6'h3B, 6'h3A: ext_alu = ALU_SRA;
      6'h03, 6'h02: ext_alu = ALU_ROL;
      default:      ext_alu = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (op_i)
      6'h06, 6'h26, 6'h20: prim_alu = ALU_CEQ;
      6'h0E, 6'h08:        prim_alu = ALU_CLE;
      6'h16, 6'h10:        prim_alu = ALU_CGT;
      6'h1E, 6'h18:        prim_alu = ALU_CNE;
      6'h2E, 6'h28:        prim_alu = ALU_CLEU;
      6'h36, 6'h30:        prim_alu = ALU_CGTU;
      6'h0C:               prim_alu = ALU_AND;
      6'h14, 6'h34:        prim_alu = ALU_OR;
      6'h1C:               prim_alu = ALU_XOR;
      default:             prim_alu = ALU_ADD;
    endcase
  end

  assign alu_op_o = (op_i == OP_REGFMT) ? ext_alu : prim_alu;
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
  import mcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OP_W-1:0]  op_i,
  input  logic [OP_W-1:0]  opx_i,
  output logic             ir_en_o,
  output logic             pc_en_o,
  output logic             pc_add_imm_o,
  output logic             pc_sel_a_o,
  output logic             pc_sel_imm_o,
  output logic             rf_we_o,
  output logic             wsel_rc_o,
  output logic             wsel_ra_o,
  output logic             wdata_pc_o,
  output logic             wdata_mem_o,
  output logic             b_reg_o,
  output logic             imm_signed_o,
  output logic             branch_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             addr_data_o,
  output logic [ALU_W-1:0] alu_op_o
);
  mcc_state_e state_q, state_d;
  mcc_ctrl_t  ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH_A;
    else         state_q <= state_d;
  end

  mcc_next u_next (
    .state_i (state_q),
    .op_i    (op_i),
    .opx_i   (opx_i),
    .next_o  (state_d)
  );

  mcc_outputs u_outputs (
    .state_i (state_q),
    .ctrl_o  (ctrl)
  );

  mcc_alu_map u_alu_map (
    .op_i     (op_i),
    .opx_i    (opx_i),
    .alu_op_o (alu_op_o)
  );

  assign ir_en_o      = ctrl.ir_en;
  assign pc_en_o      = ctrl.pc_en;
  assign pc_add_imm_o = ctrl.pc_add_imm;
  assign pc_sel_a_o   = ctrl.pc_sel_a;
  assign pc_sel_imm_o = ctrl.pc_sel_imm;
  assign rf_we_o      = ctrl.rf_we;
  assign wsel_rc_o    = ctrl.wsel_rc;
  assign wsel_ra_o    = ctrl.wsel_ra;
  assign wdata_pc_o   = ctrl.wdata_pc;
  assign wdata_mem_o  = ctrl.wdata_mem;
  assign b_reg_o      = ctrl.b_reg;
  assign imm_signed_o = ctrl.imm_signed;
  assign branch_o     = ctrl.branch;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign addr_data_o  = ctrl.addr_data;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk
  import mcc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input mcc_state_e       state_i,
  input logic [OP_W-1:0]  op_i,
  input logic             ir_en_o,
  input logic             pc_en_o,
  input logic             pc_add_imm_o,
  input logic             pc_sel_a_o,
  input logic             pc_sel_imm_o,
  input logic             rf_we_o,
  input logic             branch_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             addr_data_o,
  input logic [ALU_W-1:0] alu_op_o
);
  logic [1:0] pc_cnt_q;
  logic       in_front;

  assign in_front = (state_i == ST_FETCH_A) || (state_i == ST_FETCH_B) ||
                    (state_i == ST_DECODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pc_cnt_q <= '0;
    else if (state_i == ST_FETCH_A) pc_cnt_q <= {1'b0, pc_en_o};
    else if (in_front && pc_cnt_q != 2'd3)
      pc_cnt_q <= pc_cnt_q + {1'b0, pc_en_o};
  end

  // R2
  front_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_front |-> !mem_wr_o && !rf_we_o && !branch_o);

  // R3
  ir_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_en_o |-> $past(mem_rd_o) && !addr_data_o);

  // R4
  single_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DECODE |-> (pc_cnt_q + {1'b0, pc_en_o}) == 2'd1);

  // R4
  plain_increment_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_front && pc_en_o |-> !pc_add_imm_o && !pc_sel_a_o && !pc_sel_imm_o);

  // R8
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_LD_ADDR |-> mem_rd_o && addr_data_o && !rf_we_o);

  // R9
  store_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> addr_data_o && !rf_we_o && !pc_en_o);

  // R10
  br_always_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o && op_i == OP_BR_ALWAYS |->
      (alu_op_o == ALU_CLE || alu_op_o == ALU_CEQ || alu_op_o == ALU_CLEU));

  // R13
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_HALT |=> state_i == ST_HALT && !pc_en_o && !ir_en_o);

  // R14
  exec_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_front && state_i != ST_LD_ADDR && state_i != ST_HALT |=>
      state_i == ST_FETCH_A);
endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .op_i         (op_i),
  .ir_en_o      (ir_en_o),
  .pc_en_o      (pc_en_o),
  .pc_add_imm_o (pc_add_imm_o),
  .pc_sel_a_o   (pc_sel_a_o),
  .pc_sel_imm_o (pc_sel_imm_o),
  .rf_we_o      (rf_we_o),
  .branch_o     (branch_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .addr_data_o  (addr_data_o),
  .alu_op_o     (alu_op_o)
);

// File: tb/mcc_ctrl_bench.sv
`timescale 1ns/1ps
module mcc_ctrl_bench;
  // control vector bit positions (bench packing order)
  localparam int B_IR = 15, B_PCE = 14, B_ADDI = 13, B_PCA = 12, B_PCI = 11,
                 B_RFW = 10, B_WRC = 9, B_WRA = 8, B_WPC = 7, B_WMEM = 6,
                 B_BREG = 5, B_SIGN = 4, B_BR = 3, B_RD = 2, B_WR = 1,
                 B_DADR = 0;
  localparam logic [15:0] V_F1    = 16'd1 << B_RD;
  localparam logic [15:0] V_F2    = (16'd1 << B_IR) | (16'd1 << B_PCE);
  localparam logic [15:0] V_ZERO  = 16'd0;
  localparam logic [15:0] V_REG   = (16'd1 << B_RFW) | (16'd1 << B_WRC) | (16'd1 << B_BREG);
  localparam logic [15:0] V_REGI  = (16'd1 << B_RFW) | (16'd1 << B_WRC);
  localparam logic [15:0] V_IMMS  = (16'd1 << B_RFW) | (16'd1 << B_SIGN);
  localparam logic [15:0] V_IMMU  = 16'd1 << B_RFW;
  localparam logic [15:0] V_LD1   = (16'd1 << B_RD) | (16'd1 << B_DADR) | (16'd1 << B_SIGN);
  localparam logic [15:0] V_LD2   = (16'd1 << B_WMEM) | (16'd1 << B_RFW);
  localparam logic [15:0] V_ST    = (16'd1 << B_WR) | (16'd1 << B_DADR) | (16'd1 << B_SIGN);
  localparam logic [15:0] V_BR    = (16'd1 << B_BR) | (16'd1 << B_BREG) | (16'd1 << B_ADDI) |
                                    (16'd1 << B_SIGN);
  localparam logic [15:0] V_CALL  = (16'd1 << B_PCE) | (16'd1 << B_PCI) | (16'd1 << B_WPC) |
                                    (16'd1 << B_WRA) | (16'd1 << B_RFW);
  localparam logic [15:0] V_CALLR = (16'd1 << B_PCE) | (16'd1 << B_PCA) | (16'd1 << B_WPC) |
                                    (16'd1 << B_WRA) | (16'd1 << B_RFW);
  localparam logic [15:0] V_JMP   = (16'd1 << B_PCE) | (16'd1 << B_PCA);
  localparam logic [15:0] V_JMPI  = (16'd1 << B_PCE) | (16'd1 << B_PCI);

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] op_i = 6'h00;
  logic [5:0] opx_i = 6'h00;
  logic ir_en_o, pc_en_o, pc_add_imm_o, pc_sel_a_o, pc_sel_imm_o, rf_we_o;
  logic wsel_rc_o, wsel_ra_o, wdata_pc_o, wdata_mem_o, b_reg_o, imm_signed_o;
  logic branch_o, mem_rd_o, mem_wr_o, addr_data_o;
  logic [5:0] alu_op_o;

  int n_checks = 0;
  int n_errors = 0;
  string f1_tag = "R2";

  typedef struct {
    logic [15:0] ctl;
    logic [5:0]  alu;
    logic        chk_alu;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk_i = ~clk_i;

  mcc_ctrl u_mcc_ctrl (
    .clk_i, .rst_ni, .op_i, .opx_i, .ir_en_o, .pc_en_o, .pc_add_imm_o,
    .pc_sel_a_o, .pc_sel_imm_o, .rf_we_o, .wsel_rc_o, .wsel_ra_o,
    .wdata_pc_o, .wdata_mem_o, .b_reg_o, .imm_signed_o, .branch_o,
    .mem_rd_o, .mem_wr_o, .addr_data_o, .alu_op_o
  );

  function automatic logic [15:0] act_ctl();
    return {ir_en_o, pc_en_o, pc_add_imm_o, pc_sel_a_o, pc_sel_imm_o, rf_we_o,
            wsel_rc_o, wsel_ra_o, wdata_pc_o, wdata_mem_o, b_reg_o,
            imm_signed_o, branch_o, mem_rd_o, mem_wr_o, addr_data_o};
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input logic [15:0] c, input logic [5:0] a,
                      input logic ca, input string t);
    item_t it;
    it.ctl = c; it.alu = a; it.chk_alu = ca; it.tag = t;
    sb_q.push_back(it);
  endtask

  // called right after a falling edge while the machine is in the first fetch state
  task automatic run_instr(input logic [5:0] op, input logic [5:0] opx,
                           input logic [15:0] e1, input logic [15:0] e2,
                           input int n_exec, input logic [5:0] alu,
                           input string t);
    op_i  = op;
    opx_i = opx;
    push(V_F1, 6'd0, 1'b0, f1_tag);
    f1_tag = "R2";
    push(V_F2, 6'd0, 1'b0, "R3");
    push(V_ZERO, 6'd0, 1'b0, "R4");
    if (n_exec > 0) push(e1, alu, 1'b1, t);
    if (n_exec > 1) push(e2, alu, 1'b1, t);
    repeat (3 + n_exec) @(negedge clk_i);
  endtask

  // monitor: compares one expected item per cycle, just after the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(act_ctl() == it.ctl, it.tag, "ctrl", act_ctl(), it.ctl);
        if (it.chk_alu)
          check(alu_op_o == it.alu, it.tag, "alu",
                {10'd0, alu_op_o}, {10'd0, it.alu});
      end
    end
  end

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(act_ctl() == V_F1, "R1", "reset ctrl", act_ctl(), V_F1);
    rst_ni = 1'b1;

    run_instr(6'h3A, 6'h31, V_REG,  V_ZERO, 1, 6'b000000, "R5");
    run_instr(6'h3A, 6'h39, V_REG,  V_ZERO, 1, 6'b001000, "R5");
    run_instr(6'h3A, 6'h12, V_REGI, V_ZERO, 1, 6'b110010, "R6");
    run_instr(6'h04, 6'h00, V_IMMS, V_ZERO, 1, 6'b000000, "R7");
    run_instr(6'h08, 6'h00, V_IMMS, V_ZERO, 1, 6'b011001, "R7");
    run_instr(6'h0C, 6'h00, V_IMMU, V_ZERO, 1, 6'b100001, "R7");
    run_instr(6'h34, 6'h00, V_IMMU, V_ZERO, 1, 6'b100010, "R7");
    run_instr(6'h17, 6'h00, V_LD1,  V_LD2,  2, 6'b000000, "R8");
    run_instr(6'h15, 6'h00, V_ST,   V_ZERO, 1, 6'b000000, "R9");
    run_instr(6'h06, 6'h00, V_BR,   V_ZERO, 1, 6'b011100, "R10");
    run_instr(6'h0E, 6'h00, V_BR,   V_ZERO, 1, 6'b011001, "R10");
    run_instr(6'h00, 6'h00, V_CALL, V_ZERO, 1, 6'b000000, "R11");
    run_instr(6'h3A, 6'h1D, V_CALLR, V_ZERO, 1, 6'b000000, "R11");
    run_instr(6'h3A, 6'h0D, V_JMP,  V_ZERO, 1, 6'b000000, "R12");
    run_instr(6'h3A, 6'h05, V_JMP,  V_ZERO, 1, 6'b000000, "R12");
    run_instr(6'h01, 6'h00, V_JMPI, V_ZERO, 1, 6'b000000, "R12");
    // R14 undefined primary then undefined extended opcode: decode falls back to fetch
    run_instr(6'h3F, 6'h00, V_ZERO, V_ZERO, 0, 6'b000000, "R14");
    f1_tag = "R14";
    run_instr(6'h3A, 6'h3F, V_ZERO, V_ZERO, 0, 6'b000000, "R14");
    f1_tag = "R14";
    run_instr(6'h3A, 6'h31, V_REG,  V_ZERO, 1, 6'b000000, "R5");

    // R1 asynchronous reset in the middle of an execute state
    op_i = 6'h04;
    repeat (3) @(negedge clk_i);
    check(act_ctl() == V_IMMS, "R1", "pre-reset exec", act_ctl(), V_IMMS);
    #3 rst_ni = 1'b0;
    #1 check(act_ctl() == V_F1, "R1", "async reset", act_ctl(), V_F1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_instr(6'h3A, 6'h12, V_REGI, V_ZERO, 1, 6'b110010, "R6");

    // R13 halt stays, even when the opcode inputs change
    run_instr(6'h3A, 6'h34, V_ZERO, V_ZERO, 2, 6'b000000, "R13");
    op_i  = 6'h04;
    opx_i = 6'h00;
    repeat (4) push(V_ZERO, 6'd0, 1'b0, "R13");
    repeat (4) @(negedge clk_i);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule